// File: doc/BRIEF.md
# Converter event flag register set

This block collects the event pulses of a data converter into a bank of twelve sticky flags. Software reaches it through a plain register bus: one write port and one combinationally decoded read port. Each flag goes high in the cycle after its event pulse. It stays high until software clears it, either through a write-1-to-clear register or, for the four result-slot flags, by reading the matching result register. The bus read strobe for that register is wired to this block.

A mask register selects which flags may reach the single interrupt line. The masked status is visible as a register of its own. A write-1-to-set register lets diagnostic software inject any event without involving the converter.

Top module: `evt_flag_regs`

## Requirements
- R1: After reset the mask, raw status and masked status all read zero and `irq` is low.
- R2: An event pulse on `ev_pulse[k]` sets raw bit k in the next cycle whatever the mask holds. The bit map is: 0 overflow, 1 trigger overflow, 2 high threshold, 3 low threshold, 4 in-range, 5 DMA done, 6 underflow, 7 ad-hoc done, 8+i result loaded in slot i (i = 0..3). A raw bit holds its value while no event, set, clear or slot read touches it.
- R3: The masked status register (offset 0x08) reads raw status AND mask.
- R4: Writing 1 to a bit of the set register (offset 0x0C) sets that raw bit in the next cycle.
- R5: Writing 1 to a bit of the clear register (offset 0x10) clears that raw bit in the next cycle. Bits written 0 are left unchanged.
- R6: A pulse on `res_rd[i]` clears raw bit 8+i in the next cycle.
- R7: When a hardware event and a clear (by register or by slot read) hit the same bit in one cycle, the bit ends set.
- R8: `irq` is high exactly when some masked status bit is 1.
- R9: The set and clear registers read zero. Writes to the raw (0x04) and masked (0x08) offsets, or to unmapped offsets, change nothing.
- R10: The mask register (offset 0x00) is read/write in bits 11:0. Bits 31:12 of every register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ev_pulse | input | 12 | Single-cycle hardware event pulses, one per flag |
| res_rd | input | 4 | Read strobes of the four result registers |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The in-line assertions cover the following on every cycle:
- a pulsed event is set in the next cycle, even when a clear arrives with it;
- a written clear or a slot read removes a flag that nothing re-sets;
- an untouched raw status stays put;
- a zero mask keeps `irq` low;
- the upper read bits stay zero.

The readable encoding of each register is shown only by the bench scenarios:
- the bit map of the events;
- set and clear bits written as zero;
- read-as-zero set and clear registers;
- ignored writes to status offsets.

Long random runs against a bench model compare raw, mask, masked and interrupt after every cycle.

// File: rtl/evt_flag_regs.sv
module evt_flag_regs #(
  parameter int NSRC      = 12,
  parameter int NSLOT     = 4,
  parameter int SLOT_BASE = 8,
  parameter int AW        = 5,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NSRC-1:0]  ev_pulse,
  input  logic [NSLOT-1:0] res_rd,
  output logic          irq
);
  localparam logic [AW-1:0] OFF_MASK = AW'(0);
  localparam logic [AW-1:0] OFF_RAW  = AW'(4);
  localparam logic [AW-1:0] OFF_MIS  = AW'(8);
  localparam logic [AW-1:0] OFF_SET  = AW'(12);
  localparam logic [AW-1:0] OFF_CLR  = AW'(16);
  localparam int PAD = DW - NSRC;

  logic [NSRC-1:0] mask_q, raw_q, mis;
  logic [NSRC-1:0] set_v, clr_v, rdclr_v;

  assign set_v = (wr_en && addr == OFF_SET) ? wdata[NSRC-1:0] : '0;
  assign clr_v = (wr_en && addr == OFF_CLR) ? wdata[NSRC-1:0] : '0;
  assign mis   = raw_q & mask_q;
  assign irq   = |mis;

  always_comb begin
    rdclr_v = '0;
    for (int i = 0; i < NSLOT; i++) rdclr_v[SLOT_BASE+i] = res_rd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      if (wr_en && addr == OFF_MASK) mask_q <= wdata[NSRC-1:0];
      raw_q <= (raw_q & ~(clr_v | rdclr_v)) | ev_pulse | set_v;
    end
  end

  always_comb begin
    case (addr)
      OFF_MASK: rdata = {{PAD{1'b0}}, mask_q};
      OFF_RAW:  rdata = {{PAD{1'b0}}, raw_q};
      OFF_MIS:  rdata = {{PAD{1'b0}}, mis};
      default:  rdata = '0;
    endcase
  end

  // R7: a pulsed event is present next cycle regardless of any clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse != '0) |=> ((raw_q & $past(ev_pulse)) == $past(ev_pulse)));

  // R5: register clear removes bits not re-set in the same cycle
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CLR) |=>
      ((raw_q & $past(wdata[NSRC-1:0]) & ~$past(ev_pulse)) == '0));

  // R2: raw status holds when nothing acts on it
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse == '0 && res_rd == '0 && !(wr_en && (addr == OFF_SET || addr == OFF_CLR)))
      |=> (raw_q == $past(raw_q)));

  // R8: a zero mask keeps the interrupt low
  a_r8_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R10: upper read bits are always zero
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NSRC] == '0);

  // R6: a slot read clears its flag unless re-set in the same cycle
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot_chk
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (res_rd[g] && !ev_pulse[SLOT_BASE+g] && !(wr_en && addr == OFF_SET && wdata[SLOT_BASE+g]))
        |=> !raw_q[SLOT_BASE+g]);
  end
endmodule

// File: tb/evt_flag_regs_test.sv
`timescale 1ns/1ps
module evt_flag_regs_test;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [11:0] ev_pulse = 0;
  logic [3:0]  res_rd = 0;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [11:0] m_raw = 0, m_mask = 0;

  always #2 clk = ~clk;

  evt_flag_regs uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                     .rdata(rdata), .ev_pulse(ev_pulse), .res_rd(res_rd), .irq(irq));

  function automatic logic [11:0] next_raw(logic [11:0] raw, logic w, logic [4:0] a,
                                           logic [31:0] d, logic [11:0] e, logic [3:0] r);
    logic [11:0] s = (w && a == 5'd12) ? d[11:0] : 12'h0;
    logic [11:0] c = (w && a == 5'd16) ? d[11:0] : 12'h0;
    logic [11:0] rb = {r, 8'h00};
    return (raw & ~(c | rb)) | e | s;
  endfunction

  task automatic step(input logic w, input logic [4:0] a, input logic [31:0] d,
                      input logic [11:0] e, input logic [3:0] r);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; ev_pulse = e; res_rd = r;
    @(posedge clk);
    m_raw = next_raw(m_raw, w, a, d, e, r);
    if (w && a == 5'd0) m_mask = d[11:0];
    #1;
    wr_en = 0; ev_pulse = 0; res_rd = 0;
  endtask

  task automatic chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #0.2;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    chk(5'd4, {20'h0, m_raw}, tag);
    chk(5'd0, {20'h0, m_mask}, tag);
    chk(5'd8, {20'h0, m_raw & m_mask}, tag);
    chk_irq(|(m_raw & m_mask), tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(5'd0, 0, "R1 mask"); chk(5'd4, 0, "R1 raw"); chk(5'd8, 0, "R1 masked");
    chk_irq(0, "R1");
    // R2 each event bit lands at its position with mask zero
    for (int k = 0; k < 12; k++) begin
      step(0, 0, 0, 12'(1 << k), 0);
      chk(5'd4, 32'(1 << k), "R2 event bit");
      chk_irq(0, "R2 masked off");
      step(1, 5'd16, 32'hFFF, 0, 0);
    end
    // R4 set register
    step(1, 5'd12, 32'hFFFF_FA5A, 0, 0);
    chk(5'd4, 32'hA5A, "R4 set");
    // R9 set/clear read zero
    chk(5'd12, 0, "R9 set reads zero"); chk(5'd16, 0, "R9 clear reads zero");
    // R5 zero write no effect, then partial clear
    step(1, 5'd16, 0, 0, 0);
    chk(5'd4, 32'hA5A, "R5 zero clear");
    step(1, 5'd16, 32'h00A, 0, 0);
    chk(5'd4, 32'hA50, "R5 clear");
    // R10 mask r/w, upper bits zero
    step(1, 5'd0, 32'hFFFF_FFFF, 0, 0);
    chk(5'd0, 32'hFFF, "R10 mask");
    chk(5'd8, 32'hA50, "R3 masked"); chk_irq(1, "R8 irq high");
    step(1, 5'd0, 32'h00F, 0, 0);
    chk(5'd8, 0, "R3 masked off"); chk_irq(0, "R8 irq low");
    // R9 writes to status offsets ignored
    step(1, 5'd4, 0, 0, 0); step(1, 5'd8, 0, 0, 0); step(1, 5'd20, 32'hFFF, 0, 0);
    chk(5'd4, 32'hA50, "R9 raw write ignored");
    chk(5'd0, 32'h00F, "R9 mask untouched");
    // R6 slot read clears
    step(0, 0, 0, 0, 4'b1000);
    chk(5'd4, 32'h250, "R6 slot read");
    // R7 event beats slot read and register clear
    step(0, 0, 0, 12'h200, 4'b0010);
    chk(5'd4, 32'h250, "R7 event vs read");
    step(1, 5'd16, 32'h010, 12'h010, 0);
    chk(5'd4, 32'h250, "R7 event vs clear");
    step(1, 5'd16, 32'hFFF, 0, 0);
    chk_model("R5 clear all");
    // random phase
    for (int n = 0; n < 1500; n++) begin
      int op = $urandom % 6;
      logic [11:0] e = ($urandom % 3 == 0) ? 12'($urandom) : 12'h0;
      logic [3:0] r = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      logic [31:0] d = $urandom;
      case (op)
        0: step(1, 5'd0, d, e, r);
        1: step(1, 5'd12, d & 32'h0000_0111, e, r);
        2: step(1, 5'd16, d, e, r);
        3: step(1, 5'($urandom % 3 == 0 ? 4 : ($urandom % 2 ? 8 : 24)), d, e, r);
        default: step(0, 0, 0, e, r);
      endcase
      chk_model("R2 R3 R4 R5 R6 R7 R8 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule